// File: doc/BRIEF.md
# Command-Word Stream Decoder

This block takes the payload bytes of a serial-bus write and interprets them as command words. A command word is a control byte followed by one data byte. Bit 7 of the control byte is the continuation flag. When it is set, another control byte follows the data byte. When it is clear, every later byte of the transfer is data. Bit 6 of the control byte is the destination flag. When it is clear, data bytes go to the device-setup command output. When it is set, data bytes go to the display-RAM write port.

Display-RAM writes use the address held in a data pointer. The pointer steps by one after each stored byte and returns to zero after a parameterised last address. Logic that decodes commands can load the pointer through a side input. A STOP or a repeated START is reported on a single frame-end strobe. It returns the decoder to expecting a control byte and leaves the pointer unchanged. Each read request returns the status byte presented at the input, whatever mode the decoder is in. Display RAM cannot be read back.

Top module: `cw_stream_decoder`

## Requirements
- R1: After reset, `cmd_valid`, `ram_we` and `rd_valid` are low, the data pointer is 0, and the first byte received is taken as a control byte.
- R2: A control byte with bit 7 = 1 is followed by exactly one data byte. The byte after that data byte is parsed as a control byte again.
- R3: A control byte with bit 7 = 0 makes every following byte a data byte until the frame-end strobe. This holds even for data bytes that have bit 7 or bit 6 set.
- R4: Bit 6 of the most recent control byte routes data bytes. With bit 6 = 0 the byte appears on `cmd_byte` with `cmd_valid`. With bit 6 = 1 it appears on `ram_wdata` with `ram_we`. Bits 5..0 of a control byte have no effect.
- R5: A control byte raises neither `cmd_valid` nor `ram_we`.
- R6: Each accepted data byte raises exactly one of `cmd_valid` and `ram_we`, for exactly one cycle, in the cycle after `wr_valid`.
- R7: A RAM write carries the current pointer value on `ram_addr`. The pointer then advances by one.
- R8: After a RAM write at `LAST_ADDR`, the pointer wraps to 0.
- R9: `ptr_load` sets the pointer to `ptr_load_val`, and a load takes priority over an advance in the same cycle. A RAM write in that cycle still uses the old pointer.
- R10: `frame_end` returns the decoder to expecting a control byte and keeps the pointer value. A byte presented in the same cycle as `frame_end` is dropped.
- R11: `rd_req` produces `rd_valid` for one cycle in the next cycle, with `rd_data` equal to the `status_in` value sampled at the request. This happens in every parsing mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One-cycle strobe: a received write byte is present |
| wr_byte | input | 8 | Received write byte |
| frame_end | input | 1 | One-cycle strobe on STOP or repeated START |
| rd_req | input | 1 | One-cycle strobe: a read byte is requested |
| status_in | input | 8 | Device status byte to return on reads |
| rd_valid | output | 1 | Status byte valid on `rd_data` |
| rd_data | output | 8 | Returned status byte |
| ptr_load | input | 1 | Load the data pointer |
| ptr_load_val | input | ADDR_W | Value to load into the pointer |
| cmd_valid | output | 1 | One-cycle strobe for a command data byte |
| cmd_byte | output | 8 | Command data byte |
| ram_we | output | 1 | One-cycle display-RAM write enable |
| ram_addr | output | ADDR_W | Display-RAM write address |
| ram_wdata | output | 8 | Display-RAM write data |

## Verification
The assertions rely on a few assumptions about the inputs:
- `wr_valid`, `frame_end`, `ptr_load` and `rd_req` are single-cycle strobes from the byte interface.
- A loaded pointer value never exceeds `LAST_ADDR`. An in-range load value is itself checked by an assertion.

The stimulus drives each strobe for one cycle only, on the falling edge. It loads only in-range values. It makes `wr_valid` and `frame_end` coincide only in the one directed case that checks a byte is dropped at frame end.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
   typedef enum logic [1:0] {
      PS_CTRL   = 2'd0,
      PS_PAIR   = 2'd1,
      PS_STREAM = 2'd2
   } parse_st_t;

   localparam int CONT_BIT = 7;
   localparam int DEST_BIT = 6;
   localparam int BYTE_W   = 8;
endpackage

// File: rtl/cwd_parser.sv
module cwd_parser
   import cwd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              frame_end,
   output logic              data_fire,
   output logic              data_to_ram,
   output parse_st_t         state_o
);
   parse_st_t state_q;
   logic      dest_q;
   logic      take;

   assign take        = byte_vld && !frame_end;
   assign data_fire   = take && (state_q != PS_CTRL);
   assign data_to_ram = dest_q;
   assign state_o     = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_CTRL;
         dest_q  <= 1'b0;
      end else if (frame_end) begin
         state_q <= PS_CTRL;
      end else if (take) begin
         unique case (state_q)
            PS_CTRL: begin
               dest_q  <= byte_in[DEST_BIT];
               state_q <= byte_in[CONT_BIT] ? PS_PAIR : PS_STREAM;
            end
            PS_PAIR:   state_q <= PS_CTRL;
            PS_STREAM: state_q <= PS_STREAM;
            default:   state_q <= PS_CTRL;
         endcase
      end
   end

   a_r2_pair_back: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_PAIR && take) |=> (state_q == PS_CTRL));
   a_r3_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_STREAM && take) |=> (state_q == PS_STREAM));
   a_r10_frame_reset: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (state_q == PS_CTRL));
   a_r2_ctrl_leaves: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_CTRL && take) |=> (state_q != PS_CTRL));
endmodule

// File: rtl/cwd_ptr.sv
module cwd_ptr #(
   parameter int ADDR_W    = 10,
   parameter int LAST_ADDR = 863
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] LAST = LAST_ADDR[ADDR_W-1:0];

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_width
      $error("cwd_ptr: ADDR_W out of range");
   end
   if (LAST_ADDR < 0 || LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_last
      $error("cwd_ptr: LAST_ADDR does not fit ADDR_W");
   end

   logic [ADDR_W-1:0] nxt;

   if (LAST_ADDR == (1 << ADDR_W) - 1) begin : g_natural_wrap
      assign nxt = ptr + 1'b1;
   end else begin : g_compare_wrap
      assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (adv)  ptr <= nxt;
   end

   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
   a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && ptr == LAST) |=> (ptr == '0));
   a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ptr == $past(load_val)));
   a_r9_load_range: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val <= LAST));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(ptr));
endmodule

// File: rtl/cwd_steer.sv
module cwd_steer
   import cwd_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              to_ram,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [ADDR_W-1:0] ptr,
   output logic              adv,
   output logic              cmd_valid,
   output logic [BYTE_W-1:0] cmd_byte,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [BYTE_W-1:0] ram_wdata
);
   assign adv = fire && to_ram;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_byte  <= '0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
      end else begin
         cmd_valid <= fire && !to_ram;
         ram_we    <= adv;
         if (fire && !to_ram) cmd_byte <= byte_in;
         if (adv) begin
            ram_addr  <= ptr;
            ram_wdata <= byte_in;
         end
      end
   end

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, ram_we}));
   a_r6_one_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> $countones({cmd_valid, ram_we}) == 1);
   a_r5_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !(cmd_valid || ram_we));
   a_r7_addr: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (ram_addr == $past(ptr)));
endmodule

// File: rtl/cw_stream_decoder.sv
module cw_stream_decoder
   import cwd_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int LAST_ADDR = 863
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [7:0]        wr_byte,
   input  logic              frame_end,
   input  logic              rd_req,
   input  logic [7:0]        status_in,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   input  logic              ptr_load,
   input  logic [ADDR_W-1:0] ptr_load_val,
   output logic              cmd_valid,
   output logic [7:0]        cmd_byte,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata
);
   logic              fire;
   logic              to_ram;
   logic              adv;
   logic [ADDR_W-1:0] ptr;
   parse_st_t         pstate;

   cwd_parser u_parser (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld    (wr_valid),
      .byte_in     (wr_byte),
      .frame_end   (frame_end),
      .data_fire   (fire),
      .data_to_ram (to_ram),
      .state_o     (pstate)
   );

   cwd_ptr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .load     (ptr_load),
      .load_val (ptr_load_val),
      .ptr      (ptr)
   );

   cwd_steer #(.ADDR_W(ADDR_W)) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .to_ram    (to_ram),
      .byte_in   (wr_byte),
      .ptr       (ptr),
      .adv       (adv),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= status_in;
      end
   end

   a_r11_status: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (rd_valid && rd_data == $past(status_in)));
   a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !(cmd_valid || ram_we));
   a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      pstate != 2'd3);
endmodule

// File: tb/tb_cw_stream_decoder.sv
module tb_cw_stream_decoder;
   localparam int AW   = 4;
   localparam int LAST = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [7:0]    wr_byte = '0;
   logic          frame_end = 1'b0;
   logic          rd_req = 1'b0;
   logic [7:0]    status_in = '0;
   logic          rd_valid;
   logic [7:0]    rd_data;
   logic          ptr_load = 1'b0;
   logic [AW-1:0] ptr_load_val = '0;
   logic          cmd_valid;
   logic [7:0]    cmd_byte;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_wdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cw_stream_decoder #(.ADDR_W(AW), .LAST_ADDR(LAST)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
      .frame_end(frame_end), .rd_req(rd_req), .status_in(status_in),
      .rd_valid(rd_valid), .rd_data(rd_data), .ptr_load(ptr_load),
      .ptr_load_val(ptr_load_val), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   // Vector fields: [15:14] op (0 byte, 1 frame end), [13:12] expected
   // strobe (0 none, 1 command, 2 RAM), [11:8] expected address, [7:0] byte.
   localparam int NV = 23;
   localparam logic [15:0] VEC [NV] = '{
      16'h0080, 16'h1021, 16'h00C0, 16'h2055, 16'h00BF, 16'h10C3,
      16'h0040, 16'h2180, 16'h22C0, 16'h2300, 16'h4000,
      16'h0000, 16'h10FF, 16'h1080, 16'h4000,
      16'h0040, 16'h2411, 16'h2512, 16'h2613, 16'h2714, 16'h2015, 16'h2116,
      16'h4000
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic v, input logic [7:0] b, input logic fe);
      wr_valid  = v;
      wr_byte   = b;
      frame_end = fe;
      @(negedge clk);
      wr_valid  = 1'b0;
      frame_end = 1'b0;
   endtask

   task automatic expect_out(input string req, input int kind,
                             input logic [7:0] b, input logic [AW-1:0] a);
      chk(req, {31'd0, cmd_valid}, {31'd0, kind == 1});
      chk(req, {31'd0, ram_we}, {31'd0, kind == 2});
      if (kind == 1) chk(req, {24'd0, cmd_byte}, {24'd0, b});
      if (kind == 2) begin
         chk(req, {24'd0, ram_wdata}, {24'd0, b});
         chk(req, {28'd0, ram_addr}, {28'd0, a});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", {29'd0, cmd_valid, ram_we, rd_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R5 R6 R7 R8 R10: vector walk
      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         v = VEC[i];
         if (v[15:14] == 2'd1) begin
            send(1'b0, 8'h00, 1'b1);
            expect_out("R10", 0, 8'h00, '0);
         end else begin
            send(1'b1, v[7:0], 1'b0);
            expect_out($sformatf("R2/R3/R4/R5/R7/R8 vec%0d", i),
                       int'(v[13:12]), v[7:0], v[11:8]);
         end
      end
      // R6: strobe lasts one cycle
      @(negedge clk);
      expect_out("R6", 0, 8'h00, '0);

      // R10: pointer kept across frame end (last write at 1, next at 2)
      send(1'b1, 8'h40, 1'b0);
      send(1'b1, 8'h9A, 1'b0);
      expect_out("R10 ptr kept", 2, 8'h9A, 4'd2);

      // R9: load then write
      ptr_load = 1'b1; ptr_load_val = 4'd5;
      @(negedge clk);
      ptr_load = 1'b0;
      send(1'b1, 8'h31, 1'b0);
      expect_out("R9 load", 2, 8'h31, 4'd5);
      // R9: load and write same cycle: write uses 6, pointer becomes 2
      ptr_load = 1'b1; ptr_load_val = 4'd2;
      send(1'b1, 8'h32, 1'b0);
      ptr_load = 1'b0;
      expect_out("R9 priority old", 2, 8'h32, 4'd6);
      send(1'b1, 8'h33, 1'b0);
      expect_out("R9 priority new", 2, 8'h33, 4'd2);

      // R11: status read in stream mode
      status_in = 8'hA5; rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk("R11 valid", {31'd0, rd_valid}, 32'd1);
      chk("R11 data", {24'd0, rd_data}, 32'hA5);
      expect_out("R11 no write", 0, 8'h00, '0);
      @(negedge clk);
      chk("R11 pulse", {31'd0, rd_valid}, 32'd0);

      // R10: byte with frame end is dropped, next byte is control
      send(1'b1, 8'h77, 1'b1);
      expect_out("R10 drop", 0, 8'h00, '0);
      send(1'b1, 8'h80, 1'b0);
      expect_out("R5 ctrl after fe", 0, 8'h00, '0);
      send(1'b1, 8'h44, 1'b0);
      expect_out("R4 cmd after fe", 1, 8'h44, '0);

      // R11: read while a control byte is expected
      status_in = 8'h3C; rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      chk("R11 ctrl mode", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h3C});

      // R1: reset clears pointer
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      send(1'b1, 8'hC0, 1'b0);
      send(1'b1, 8'h01, 1'b0);
      expect_out("R1 ptr zero", 2, 8'h01, 4'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule